// File: doc/BRIEF.md
# Three-Wire Serial Byte Memory Slave

This block is the device side of a three-wire serial byte memory. The array has 128 eight-bit locations held in registers. The host drives chip select, a serial clock and a data line. The block returns data or status on a data-out pin that it can release to high impedance. The three host pins are asynchronous to the system clock. They are resynchronised, and their edges are detected before any decoding.

Every command opens with a start bit of 1, followed by a two-bit opcode and a seven-bit address field:

| Command | Frame |
|---|---|
| read | opcode 10, then the address |
| write | opcode 01, then the address, then eight data bits, most significant first |
| enable programming | opcode 00, address field starting 11 |
| disable programming | opcode 00, address field starting 00 |
| fill with ones | opcode 00, address field starting 10 |

Write and fill are held until chip select falls. At that point a self-timed program cycle, counted in system clocks, takes over. It needs no further serial clocks.

A host that raises chip select during or after the cycle sees busy or ready on data-out. It clears that indication with a start bit followed by a chip-select fall.

Top module: `mw_byte_mem`

## Requirements
- R1: After reset, programming is disabled and `do_oe` is 0, including while chip select is high with no command.
- R2: While programming is disabled, a complete write frame or fill frame leaves the array unchanged, starts no program cycle and produces no status (`do_oe` stays 0 when chip select rises again).
- R3: The enable command (start 1, opcode 00, first two address bits 11) permits programming until the disable command (start 1, opcode 00, first two address bits 00) runs. After a disable, a write is ignored again.
- R4: A read frame (start 1, opcode 10, seven address bits most significant first) makes data-out drive a single 0 on the rising clock that takes the last address bit. The eight bits of the addressed byte then follow, most significant first, one per rising clock.
- R5: While chip select stays high after a read, the next location's eight bits follow directly, with no further dummy bit. The address wraps from 127 to 0.
- R6: A write frame (start 1, opcode 01, seven address bits, eight data bits, all most significant first) replaces the addressed byte with the received data.
- R7: The program cycle for a write or fill begins at the chip-select fall after the last required bit. It lasts `PROG_CYCLES` system clocks with no serial clock activity. The array changes only when the cycle ends.
- R8: The fill command (start 1, opcode 00, first two address bits 10) sets every location to 0xFF.
- R9: When chip select is high after a program cycle has started, `do_oe` is 1. `do_o` is 0 while the cycle runs and 1 after it ends.
- R10: After a cycle has finished, a start bit followed by a chip-select fall clears the status indication, so `do_oe` is 0 on the next chip-select high.
- R11: A chip-select fall aborts any partially received frame. A write cut short therefore changes nothing and shows no status, and `do_oe` is 0 while chip select is low.
- R12: Frames clocked in while a program cycle is running are ignored entirely, and data-out keeps showing busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from the host, active high, asynchronous |
| sk_i | input | 1 | Serial clock from the host, asynchronous |
| di_i | input | 1 | Serial data from the host, sampled on rising serial clock |
| do_o | output | 1 | Serial data or ready/busy status toward the host |
| do_oe | output | 1 | Drive enable for `do_o`; 0 means high impedance |

## Verification
The hardest condition to reach from the pins is a complete, well-formed command arriving while a program cycle is still counting. The bench builds the cycle length up to a few hundred clocks. After starting a write, it raises chip select at once to watch busy, and clocks a full write frame to a neighbouring address inside the busy window. It then lowers chip select, waits out the cycle and reads both locations back. Wrap-around of the streaming read is reached by starting reads near address 127 and running several bytes past it.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start bit
    ST_HDR,    // shifting opcode and address
    ST_DATA,   // shifting write data
    ST_READ,   // streaming array bits out
    ST_ARMED,  // frame complete, program cycle waits for chip-select fall
    ST_SKIP    // rest of frame is don't-care
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

  // next location of a streaming read, wrapping at the array size
  function automatic int unsigned mw_wrap_next(input int unsigned addr,
                                               input int unsigned depth);
    return (addr + 1) % depth;
  endfunction

  // bit of a byte sent on a given step of its serial output (MSB first)
  function automatic int unsigned mw_bit_of_step(input int unsigned step,
                                                 input int unsigned width);
    return width - 1 - step;
  endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_edge.sv
module mw_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = lvl_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~lvl_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  // R12
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/mw_byte_mem.sv
module mw_byte_mem #(
  parameter int unsigned AW          = 7,
  parameter int unsigned DW          = 8,
  parameter int unsigned PROG_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe
);
  import mw_pkg::*;

  localparam int unsigned DEPTH    = 1 << AW;
  localparam int unsigned HDR_BITS = 2 + AW;
  localparam int unsigned MAXB     = (HDR_BITS > DW) ? HDR_BITS : DW;
  localparam int unsigned CNTW     = $clog2(MAXB);
  localparam int unsigned BW       = $clog2(DW);

  // ---------------- pin conditioning ----------------
  logic [2:0] pins_s;
  logic cs_s, sk_s, di_s, sk_rise, cs_fall;

  mw_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({di_i, sk_i, cs_i}), .lvl_o(pins_s));

  assign cs_s = pins_s[0];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[2];

  mw_edge #(.RISE(1'b1)) u_sk_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sk_s), .edge_o(sk_rise));
  mw_edge #(.RISE(1'b0)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(cs_s), .edge_o(cs_fall));

  // ---------------- state ----------------
  mw_state_e            state_q;
  logic [CNTW-1:0]      cnt_q;
  logic [HDR_BITS-2:0]  hdr_q;
  logic [DW-1:0]        wr_data_q;
  logic [AW-1:0]        wr_addr_q, rd_addr_q;
  logic [BW-1:0]        rd_cnt_q;
  logic                 do_q, wen_q, fill_q;
  logic                 st_pend_q, sb_seen_q;
  logic [DW-1:0]        mem_q [DEPTH];

  logic busy, prog_done;

  // ---------------- named events ----------------
  logic [HDR_BITS-1:0] hdr_full;
  logic [1:0]          hdr_op, hdr_ext;
  logic [AW-1:0]       hdr_addr;
  logic                bit_take, start_seen, hdr_last, data_last, rd_step;
  logic                start_prog;
  logic [BW-1:0]       rd_bit_idx;

  assign bit_take   = cs_s & sk_rise & ~busy;
  assign start_seen = bit_take & (state_q == ST_IDLE) & di_s;
  assign hdr_last   = bit_take & (state_q == ST_HDR) & (cnt_q == CNTW'(HDR_BITS - 1));
  assign data_last  = bit_take & (state_q == ST_DATA) & (cnt_q == CNTW'(DW - 1));
  assign rd_step    = bit_take & (state_q == ST_READ);
  assign start_prog = cs_fall & (state_q == ST_ARMED);

  assign hdr_full = {hdr_q, di_s};
  assign hdr_op   = hdr_full[HDR_BITS-1 -: 2];
  assign hdr_addr = hdr_full[AW-1:0];
  assign hdr_ext  = hdr_addr[AW-1 -: 2];

  assign rd_bit_idx = BW'(mw_bit_of_step(32'(rd_cnt_q), DW));

  // ---------------- frame decoder ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      wr_data_q <= '0;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      rd_cnt_q  <= '0;
      do_q      <= 1'b0;
      wen_q     <= 1'b0;
      fill_q    <= 1'b0;
    end else if (!cs_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (bit_take) begin
      unique case (state_q)
        ST_IDLE: if (di_s) begin
          state_q <= ST_HDR;
          cnt_q   <= '0;
        end
        ST_HDR: begin
          hdr_q <= hdr_full[HDR_BITS-2:0];
          cnt_q <= cnt_q + CNTW'(1);
          if (hdr_last) begin
            cnt_q   <= '0;
            state_q <= ST_SKIP;
            case (hdr_op)
              OP_READ: begin
                state_q   <= ST_READ;
                rd_addr_q <= hdr_addr;
                rd_cnt_q  <= '0;
                do_q      <= 1'b0;
              end
              OP_WRITE: if (wen_q) begin
                state_q   <= ST_DATA;
                wr_addr_q <= hdr_addr;
              end
              OP_EXT: begin
                if (hdr_ext == EXT_UNLOCK) wen_q <= 1'b1;
                if (hdr_ext == EXT_LOCK)   wen_q <= 1'b0;
                if (hdr_ext == EXT_FILL && wen_q) begin
                  state_q <= ST_ARMED;
                  fill_q  <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        ST_DATA: begin
          wr_data_q <= {wr_data_q[DW-2:0], di_s};
          cnt_q     <= cnt_q + CNTW'(1);
          if (data_last) begin
            state_q <= ST_ARMED;
            fill_q  <= 1'b0;
          end
        end
        ST_READ: begin
          do_q <= mem_q[rd_addr_q][rd_bit_idx];
          if (rd_cnt_q == BW'(DW - 1)) begin
            rd_cnt_q  <= '0;
            rd_addr_q <= AW'(mw_wrap_next(32'(rd_addr_q), DEPTH));
          end else begin
            rd_cnt_q <= rd_cnt_q + BW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- status indication ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pend_q <= 1'b0;
      sb_seen_q <= 1'b0;
    end else if (start_prog) begin
      st_pend_q <= 1'b1;
      sb_seen_q <= 1'b0;
    end else if (cs_fall) begin
      if (sb_seen_q) st_pend_q <= 1'b0;
      sb_seen_q <= 1'b0;
    end else if (start_seen && st_pend_q) begin
      sb_seen_q <= 1'b1;
    end
  end

  // ---------------- program cycle and array ----------------
  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_prog),
    .busy_o(busy), .done_o(prog_done));

  always_ff @(posedge clk) begin
    if (prog_done) begin
      if (fill_q) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else begin
        mem_q[wr_addr_q] <= wr_data_q;
      end
    end
  end

  // ---------------- data-out ----------------
  assign do_oe = cs_s & ((state_q == ST_READ) | st_pend_q);
  assign do_o  = do_oe & ((state_q == ST_READ) ? do_q : ~busy);

  // ---------------- assertions ----------------
  // R1
  reset_lock_chk: assert property (@(posedge clk)
    !rst_n |=> (!wen_q && !do_oe));
  // R2
  armed_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED || state_q == ST_DATA) |-> wen_q);
  // R11
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (state_q == ST_IDLE));
  // R11
  cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !do_oe);
  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sk_rise) |=> $stable(state_q));
  // R9
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !do_o);
  // R5
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && rd_cnt_q == BW'(DW - 1)) |=>
      (($past(rd_addr_q) == AW'(DEPTH - 1)) ? (rd_addr_q == '0)
                                            : (rd_addr_q == $past(rd_addr_q) + AW'(1))));
endmodule

// File: tb/mw_byte_mem_bench.sv
module mw_byte_mem_bench;
  localparam int AW     = 7;
  localparam int DEPTH  = 1 << AW;
  localparam int PROG_T = 300;
  localparam int H      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  logic smp_do, smp_oe;

  int n_chk = 0;
  int n_err = 0;
  int model [DEPTH];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mw_byte_mem #(.AW(AW), .DW(8), .PROG_CYCLES(PROG_T), .SYNC_STAGES(2)) u_mw_byte_mem (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_oe(do_oe));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    di = b;
    tick(H);
    sk = 1'b1;
    tick(H);
    smp_do = do_o;
    smp_oe = do_oe;
    sk = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1;
    tick(H);
  endtask

  task automatic cs_down();
    tick(H);
    cs = 1'b0;
    sk = 1'b0;
    tick(H);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic ext_cmd(input logic [1:0] code);
    cs_up();
    send_hdr(2'b00, {code, 5'b0});
    cs_down();
  endtask

  task automatic write_frame(input int a, input int d, input int nbits);
    logic [7:0] dv;
    dv = 8'(d);
    cs_up();
    send_hdr(2'b01, AW'(a));
    for (int i = 0; i < nbits; i++) clk_bit(dv[7-i]);
    cs_down();
  endtask

  // called right after a frame ended with chip select low
  task automatic status_phase(input string req, input bit started);
    cs = 1'b1;
    tick(8);
    if (started) begin
      chk({req, " R9 busy oe"}, int'(do_oe), 1);
      chk({req, " R9 busy level"}, int'(do_o), 0);
      tick(PROG_T + 10);
      chk({req, " R9 ready level"}, int'(do_o), 1);
      clk_bit(1'b1);
      cs_down();
      cs_up();
      chk({req, " R10 status cleared"}, int'(do_oe), 0);
      cs_down();
    end else begin
      chk({req, " no status"}, int'(do_oe), 0);
      cs_down();
    end
  endtask

  task automatic read_stream(input string req, input int start, input int nbytes);
    int v;
    cs_up();
    send_hdr(2'b10, AW'(start));
    chk({req, " R4 dummy oe"}, int'(smp_oe), 1);
    chk({req, " R4 dummy zero"}, int'(smp_do), 0);
    for (int b = 0; b < nbytes; b++) begin
      v = 0;
      for (int i = 0; i < 8; i++) begin
        clk_bit(1'b0);
        v = (v << 1) | int'(smp_do);
      end
      chk(b == 0 ? {req, " R4 first byte"} : {req, " R5 stream byte"},
          v, model[(start + b) % DEPTH]);
    end
    cs_down();
    chk({req, " R11 oe low with cs low"}, int'(do_oe), 0);
  endtask

  function automatic int pat(input int a);
    return (a * 73 + 29) % 256;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(5);
    chk("R1 oe in reset", int'(do_oe), 0);
    rst_n = 1'b1;
    tick(5);
    cs_up();
    chk("R1 oe after reset", int'(do_oe), 0);
    cs_down();

    // R2: programming locked out of reset
    write_frame(5, 8'h5A, 8);
    status_phase("R2 write locked", 1'b0);
    ext_cmd(2'b10);
    status_phase("R2 fill locked", 1'b0);

    // R3 enable, R8 fill
    ext_cmd(2'b11);
    ext_cmd(2'b10);
    status_phase("R8 fill", 1'b1);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    read_stream("R8 after fill", 120, 12);

    // R6 every location written
    for (int a = 0; a < DEPTH; a++) begin
      write_frame(a, pat(a), 8);
      status_phase("R6 write", 1'b1);
      model[a] = pat(a);
    end
    read_stream("R6 full sweep", 0, DEPTH);
    read_stream("R5 wrap", 125, 6);

    // R12: full frame while busy is ignored
    write_frame(10, 8'hC3, 8);
    model[10] = 8'hC3;
    cs = 1'b1;
    tick(8);
    chk("R12 busy before frame", int'(do_o), 0);
    send_hdr(2'b01, AW'(11));
    for (int i = 0; i < 8; i++) clk_bit(1'b0);
    chk("R12 still busy", int'(do_o), 0);
    chk("R12 still driving", int'(do_oe), 1);
    cs_down();
    tick(PROG_T + 10);
    cs_up();
    chk("R7 ready without serial clock", int'(do_o), 1);
    clk_bit(1'b1);
    cs_down();
    read_stream("R12 readback", 10, 2);

    // R11: write cut short
    write_frame(20, 8'h00, 4);
    status_phase("R11 short write", 1'b0);
    read_stream("R11 readback", 20, 1);

    // R3: disable then write is ignored, re-enable works
    ext_cmd(2'b00);
    write_frame(30, 8'h00, 8);
    status_phase("R3 locked write", 1'b0);
    read_stream("R3 locked readback", 30, 1);
    ext_cmd(2'b11);
    write_frame(30, 8'h11, 8);
    status_phase("R3 reenabled write", 1'b1);
    model[30] = 8'h11;
    read_stream("R3 reenabled readback", 29, 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule